// File: doc/BRIEF.md
# Cycle-Steal Single-Channel DMA Engine

This block is one DMA channel that moves data from a source byte address to a destination byte address over a simple 32-bit memory-mapped bus. Software programs four registers: the source address, the destination address, a status word that holds the remaining byte count, and a control word. Each side has its own transfer size (byte, half word or word) and its own increment enable. A fixed destination suits a peripheral data register. A fixed source suits a peripheral FIFO.

A unit of work is as wide as the larger of the two sizes. The channel reads the source in chunks of the source size and packs them into the unit. It then writes the unit out in chunks of the destination size. The byte count drops by the unit width once the unit has been written. In cycle-steal mode, each accepted peripheral request moves exactly one unit, and then the channel waits. Otherwise, a trigger runs the channel until the count is exhausted. When the count reaches zero the channel raises a done flag, and it can also raise an interrupt.

Top module: `dma_cs`

## Requirements
- R1: Size codes are 2'b01 = byte, 2'b10 = half word and 2'b00 = word. 2'b11 is reserved. One unit is max(source size, destination size) bytes. The byte count (status bits [23:0]) drops by the unit width after the last write of each unit. With byte source and word destination, four byte reads are packed little-endian into one word write.
- R2: With source increment set (ctrl bit 5), the source address advances by the source size after every read. With it clear, every read uses the same address.
- R3: With destination increment set (ctrl bit 6), the destination address advances by the destination size after every write. With it clear, every write goes to the same address. A half-word write to an address with offset 0 uses byte enables 4'b0011 and data lanes [15:0].
- R4: Write data and byte enables sit on the lanes selected by address bits [1:0]. For example, a byte write to offset 3 uses enables 4'b1000 and lanes [31:24]. A bus request holds its address and direction until it is accepted.
- R5: With cycle-steal set (ctrl bit 2), each accepted peripheral request moves exactly one unit, and then the channel goes idle.
- R6: Writing the control word with bit 0 set starts the channel. With cycle-steal clear, the channel runs units back to back until the count reaches zero.
- R7: When the count reaches zero, done (status bit 24) is set. The interrupt output follows done while interrupt enable (ctrl bit 3) is set, and stays low otherwise.
- R8: Writing status with bit 24 set clears done and both error flags, and sets the count to zero. Any count value in the same write is discarded.
- R9: With stop-on-done (ctrl bit 4) set, reaching zero clears request enable (ctrl bit 1), and later requests move nothing.
- R10: Peripheral requests have no effect while request enable (ctrl bit 1) is clear.
- R11: A misaligned address, a count that is not a multiple of the unit, or a reserved size code sets the configuration error flag (status bit 26) when a start is attempted. No bus access is made and the count is unchanged.
- R12: Busy (status bit 25) is high from the cycle after a request is accepted until the channel goes idle. A request that arrives while busy is held and serviced next.
- R13: A bus error response sets status bit 27 and stops the channel. The count is kept, and no write of that unit is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 source, 1 destination, 2 status/count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| preq | input | 1 | Peripheral request, one request per high cycle |
| m_valid | output | 1 | Bus access request |
| m_write | output | 1 | Bus access is a write |
| m_addr | output | AW | Bus byte address |
| m_wdata | output | 32 | Bus write data |
| m_be | output | 4 | Bus byte enables |
| m_rdata | input | 32 | Bus read data |
| m_ready | input | 1 | Bus accepts the access this cycle |
| m_err | input | 1 | Bus error response with m_ready |
| irq | output | 1 | Completion interrupt |

## Verification
A start written through the control word takes effect two clock edges after the write strobe. An accepted peripheral request issues its first read on the next edge. Each bus access then completes in the cycle that m_ready is high. Expected writes (address, masked data, byte enables) are queued before the stimulus, and each is compared at the moment its bus handshake happens. Status, count and interrupt are sampled only after a waiting window that covers the longest stalled unit, so every result is already settled when it is read.

// File: rtl/dma_cs.sv
module dma_cs #(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          preq,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  output logic [3:0]    m_be,
  input  logic [31:0]   m_rdata,
  input  logic          m_ready,
  input  logic          m_err,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic done, cfg_err, bus_err;
  logic req_en, steal, irq_en, stop_on_done, src_inc, dst_inc;
  logic [1:0] ssz, dsz;
  logic go_q, pend, cont;
  logic [31:0] ubuf;
  logic [1:0] roff, woff;

  function automatic logic [2:0] nbytes(input logic [1:0] z);
    case (z)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      2'b00:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] lmask(input logic [2:0] n);
    return (n == 3'd1) ? 32'h0000_00FF : (n == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  wire [2:0] sb = nbytes(ssz);
  wire [2:0] db = nbytes(dsz);
  wire [2:0] ub = (sb > db) ? sb : db;
  wire [2:0] sm = sb - 3'd1;
  wire [2:0] dm = db - 3'd1;
  wire [2:0] um = ub - 3'd1;
  wire bad = (sb == 3'd0) || (db == 3'd0) || ((cnt[1:0] & um[1:0]) != 2'b00)
          || ((src[1:0] & sm[1:0]) != 2'b00) || ((dst[1:0] & dm[1:0]) != 2'b00);

  wire busy   = (st != S_IDLE);
  wire hw_req = preq & req_en;
  wire wr_src = cfg_wr && cfg_addr == 2'd0;
  wire wr_dst = cfg_wr && cfg_addr == 2'd1;
  wire wr_sts = cfg_wr && cfg_addr == 2'd2;
  wire wr_ctl = cfg_wr && cfg_addr == 2'd3;
  wire trig   = go_q | pend | hw_req;

  wire        rd_last = ({1'b0, roff} + sb) == ub;
  wire        wr_last = ({1'b0, woff} + db) == ub;
  wire [31:0] smask   = lmask(sb);
  wire [31:0] dmask   = lmask(db);
  wire [31:0] rsh     = (m_rdata >> {src[1:0], 3'b000}) & smask;
  wire [31:0] wsel    = (ubuf >> {woff, 3'b000}) & dmask;
  wire [3:0]  dbe     = (db == 3'd1) ? 4'b0001 : (db == 3'd2) ? 4'b0011 : 4'b1111;
  wire [CW-1:0] cnt_nx = cnt - CW'(ub);

  assign m_valid = busy;
  assign m_write = (st == S_WR);
  assign m_addr  = (st == S_WR) ? dst : src;
  assign m_wdata = wsel << {dst[1:0], 3'b000};
  assign m_be    = dbe << dst[1:0];
  assign irq     = done & irq_en;

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = 32'(src);
      2'd1:    cfg_rdata = 32'(dst);
      2'd2:    cfg_rdata = {4'b0, bus_err, cfg_err, busy, done, 24'(cnt)};
      default: cfg_rdata = {20'b0, dsz, ssz, 1'b0, dst_inc, src_inc, stop_on_done,
                            irq_en, steal, req_en, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0; dst <= '0; cnt <= '0;
      done <= 1'b0; cfg_err <= 1'b0; bus_err <= 1'b0;
      req_en <= 1'b0; steal <= 1'b0; irq_en <= 1'b0; stop_on_done <= 1'b0;
      src_inc <= 1'b0; dst_inc <= 1'b0; ssz <= 2'b00; dsz <= 2'b00;
      go_q <= 1'b0; pend <= 1'b0; cont <= 1'b0;
      ubuf <= '0; roff <= '0; woff <= '0;
    end else begin
      go_q <= wr_ctl & cfg_wdata[0];
      if (wr_src && !busy) src <= cfg_wdata[AW-1:0];
      if (wr_dst && !busy) dst <= cfg_wdata[AW-1:0];
      if (wr_sts) begin
        if (cfg_wdata[24]) begin
          done <= 1'b0; cfg_err <= 1'b0; bus_err <= 1'b0; cnt <= '0;
        end else if (!busy) begin
          cnt <= cfg_wdata[CW-1:0];
        end
      end
      if (wr_ctl) begin
        req_en <= cfg_wdata[1]; steal <= cfg_wdata[2]; irq_en <= cfg_wdata[3];
        stop_on_done <= cfg_wdata[4]; src_inc <= cfg_wdata[5]; dst_inc <= cfg_wdata[6];
        ssz <= cfg_wdata[9:8]; dsz <= cfg_wdata[11:10];
      end
      if (busy && hw_req) pend <= 1'b1;

      case (st)
        S_IDLE: if (trig) begin
          pend <= (go_q | pend) ? hw_req : 1'b0;
          if (cnt != '0 && !cfg_err && !bus_err) begin
            if (bad) cfg_err <= 1'b1;
            else begin
              st <= S_RD; roff <= '0; woff <= '0; cont <= ~steal;
            end
          end
        end
        S_RD: if (m_ready) begin
          if (m_err) begin
            bus_err <= 1'b1; st <= S_IDLE; pend <= 1'b0;
          end else begin
            ubuf <= (ubuf & ~(smask << {roff, 3'b000})) | (rsh << {roff, 3'b000});
            if (src_inc) src <= src + AW'(sb);
            if (rd_last) begin st <= S_WR; roff <= '0; end
            else roff <= roff + sb[1:0];
          end
        end
        S_WR: if (m_ready) begin
          if (m_err) begin
            bus_err <= 1'b1; st <= S_IDLE; pend <= 1'b0;
          end else begin
            if (dst_inc) dst <= dst + AW'(db);
            if (wr_last) begin
              cnt <= cnt_nx; woff <= '0;
              if (cnt_nx == '0) begin
                done <= 1'b1; st <= S_IDLE;
                if (stop_on_done) begin req_en <= 1'b0; pend <= 1'b0; end
              end else if (cont) st <= S_RD;
              else st <= S_IDLE;
            end else woff <= woff + db[1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_cs_chk #(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_write,
  input logic [AW-1:0] m_addr,
  input logic          m_err,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic          done,
  input logic          irq,
  input logic          irq_en,
  input logic          dst_inc,
  input logic          req_en,
  input logic          preq,
  input logic          pend,
  input logic          go_q,
  input logic          cfg_wr,
  input logic [1:0]    cfg_addr,
  input logic [31:0]   cfg_wdata
);
  logic seen, have_prev;
  logic [AW-1:0] last_wa;
  wire whs = m_valid && m_ready && m_write && !m_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; have_prev <= 1'b0; last_wa <= '0;
    end else begin
      seen <= 1'b1;
      if (cfg_wr && (cfg_addr == 2'd1 || cfg_addr == 2'd3)) have_prev <= 1'b0;
      else if (whs) begin have_prev <= 1'b1; last_wa <= m_addr; end
    end
  end

  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(busy) && !$past(cfg_wr) && cnt != $past(cnt)) |-> (cnt < $past(cnt)));

  assert_fixed_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (whs && !dst_inc && have_prev) |-> (m_addr == last_wa));

  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd2 && cfg_wdata[24] && !busy) |=> (!done && !irq && cnt == '0));

  assert_req_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_en && preq && !pend && !go_q) |=> !busy);

  assert_irq_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(done) && irq_en) |-> irq);
endmodule

bind dma_cs dma_cs_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
  .m_addr(m_addr), .m_err(m_err), .busy(busy), .cnt(cnt), .done(done), .irq(irq),
  .irq_en(irq_en), .dst_inc(dst_inc), .req_en(req_en), .preq(preq), .pend(pend),
  .go_q(go_q), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
);

// File: tb/dma_cs_test.sv
module dma_cs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic preq = 1'b0;
  logic m_valid, m_write, m_ready, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0] m_be;
  logic irq;
  logic stall = 1'b0;
  logic tog = 1'b0;

  always #2.5 clk = ~clk;

  dma_cs uut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .preq(preq), .m_valid(m_valid),
    .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err), .irq(irq));

  localparam int C_GO = 1, C_REQ = 2, C_STEAL = 4, C_IRQ = 8, C_STOP = 16,
                 C_SINC = 32, C_DINC = 64;
  localparam int Z_B = 1, Z_H = 2, Z_W = 0;
  localparam int B_DONE = 24, B_BUSY = 25, B_CFGE = 26, B_BUSE = 27;

  typedef struct packed { logic [31:0] a; logic [31:0] d; logic [3:0] be; } wr_t;
  wr_t exp_q[$];
  logic [7:0] mem [0:255];
  int vectors = 0, fails = 0, writes_seen = 0;

  function automatic logic [31:0] bemask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  always @(posedge clk) tog <= ~tog;
  assign m_ready = !stall || tog;
  assign m_err   = m_addr >= 32'd256;
  assign m_rdata = {mem[{m_addr[7:2], 2'd3}], mem[{m_addr[7:2], 2'd2}],
                    mem[{m_addr[7:2], 2'd1}], mem[{m_addr[7:2], 2'd0}]};

  always @(posedge clk)
    if (rst_n && m_valid && m_ready && m_write && !m_err)
      for (int b = 0; b < 4; b++)
        if (m_be[b]) mem[{m_addr[7:2], 2'(b)}] <= m_wdata[8*b +: 8];

  always @(negedge clk)
    if (rst_n && m_valid && m_ready && m_write && !m_err) begin
      wr_t e;
      writes_seen++;
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3/R4 unexpected write: actual addr=%h data=%h be=%b expected none",
                 m_addr, m_wdata, m_be);
      end else begin
        e = exp_q.pop_front();
        if (m_addr != e.a || m_be != e.be || (m_wdata & bemask(m_be)) != e.d) begin
          fails++;
          $display("FAIL R3/R4 write: actual addr=%h data=%h be=%b expected addr=%h data=%h be=%b",
                   m_addr, m_wdata & bemask(m_be), m_be, e.a, e.d, e.be);
        end
      end
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_wr(input logic [31:0] a, input int sz, input logic [31:0] v);
    wr_t e;
    logic [3:0] b0 = (sz == 1) ? 4'h1 : (sz == 2) ? 4'h3 : 4'hF;
    e.be = b0 << a[1:0];
    e.a  = a;
    e.d  = (v << (8 * a[1:0])) & bemask(e.be);
    exp_q.push_back(e);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); preq = 1'b1;
    repeat (n) @(negedge clk);
    preq = 1'b0;
  endtask

  task automatic settle(); repeat (30) @(negedge clk); endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int c, input int ctl);
    wreg(2, 32'h0100_0000);
    wreg(0, s); wreg(1, d); wreg(2, 32'(c)); wreg(3, 32'(ctl));
  endtask

  function automatic int ctl_of(input int f, input int ss, input int ds);
    return f | (ss << 8) | (ds << 10);
  endfunction

  function automatic logic [31:0] m16(input int a); return {16'b0, mem[a+1], mem[a]}; endfunction
  function automatic logic [31:0] m32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int ws;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rreg(2, r); chk("reset status", r, 32'h0);
    rreg(3, r); chk("reset ctrl", r, 32'h0);
    chk("reset irq/valid", {30'b0, irq, m_valid}, 32'h0);

    // R6 R1 R2 R3 R7: continuous half-word copy, both sides incrementing
    for (int k = 0; k < 4; k++) push_wr(32'h40 + 2*k, 2, m16(2*k));
    setup(32'h00, 32'h40, 8, ctl_of(C_GO | C_IRQ | C_SINC | C_DINC, Z_H, Z_H));
    settle();
    rreg(2, r); chk("R6 R7 done, count 0", r, 32'h0100_0000);
    chk("R7 irq with enable", {31'b0, irq}, 32'h1);
    chk("R6 all writes seen", 32'(exp_q.size()), 32'h0);
    for (int k = 0; k < 8; k++) chk("R2 copy content", {24'b0, mem[8'h40 + k]}, {24'b0, mem[k]});

    // R8: done-clear write discards count
    wreg(2, 32'h0100_0008);
    rreg(2, r); chk("R8 w1c resets count/done", r, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);

    // R5 R3: cycle steal, fixed half-word destination
    setup(32'h10, 32'h80, 6, ctl_of(C_REQ | C_STEAL | C_SINC, Z_H, Z_H));
    for (int k = 0; k < 3; k++) begin
      ws = writes_seen;
      push_wr(32'h80, 2, m16(16 + 2*k));
      pulse(1);
      settle();
      chk("R5 one write per request", 32'(writes_seen - ws), 32'h1);
      rreg(2, r); chk("R1 count per request", r & 32'h00FF_FFFF, 32'(4 - 2*k));
    end
    rreg(2, r); chk("R7 done without irq", r, 32'h0100_0000);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);

    // R10: requests ignored while request enable is clear
    setup(32'h10, 32'h80, 4, ctl_of(C_STEAL | C_SINC, Z_H, Z_H));
    ws = writes_seen;
    pulse(1); settle();
    chk("R10 no write", 32'(writes_seen - ws), 32'h0);
    rreg(2, r); chk("R10 count kept", r, 32'h4);

    // R9 R2 R4: fixed byte source, stop-on-done
    setup(32'h20, 32'h90, 2, ctl_of(C_REQ | C_STEAL | C_STOP | C_DINC, Z_B, Z_B));
    push_wr(32'h90, 1, {24'b0, mem[32]});
    push_wr(32'h91, 1, {24'b0, mem[32]});
    pulse(1); settle(); pulse(1); settle();
    rreg(3, r); chk("R9 request enable cleared", r & 32'h2, 32'h0);
    ws = writes_seen;
    pulse(1); settle();
    chk("R9 later request moves nothing", 32'(writes_seen - ws), 32'h0);
    rreg(2, r); chk("R9 done, count 0", r, 32'h0100_0000);

    // R12: second request while busy is pending, stalled bus
    stall = 1'b1;
    setup(32'h30, 32'hA0, 4, ctl_of(C_REQ | C_STEAL | C_SINC | C_DINC, Z_H, Z_H));
    push_wr(32'hA0, 2, m16(48));
    push_wr(32'hA2, 2, m16(50));
    ws = writes_seen;
    @(negedge clk); preq = 1'b1;
    @(negedge clk); cfg_addr = 2; #1 chk("R12 busy after accept", cfg_rdata & (32'h1 << B_BUSY), 32'h1 << B_BUSY);
    @(negedge clk); preq = 1'b0;
    settle();
    chk("R12 pending serviced", 32'(writes_seen - ws), 32'h2);
    rreg(2, r); chk("R12 count 0 and idle", r, 32'h0100_0000);
    stall = 1'b0;

    // R1 R4: byte reads packed into one word write
    push_wr(32'hB0, 4, m32(80));
    setup(32'h50, 32'hB0, 4, ctl_of(C_GO | C_SINC | C_DINC, Z_B, Z_W));
    settle();
    rreg(2, r); chk("R1 packed unit done", r, 32'h0100_0000);
    chk("R1 packed write seen", 32'(exp_q.size()), 32'h0);

    // R4: word read to fixed byte destination at lane 3
    for (int k = 0; k < 4; k++) push_wr(32'hC3, 1, {24'b0, mem[84 + k]});
    setup(32'h54, 32'hC3, 4, ctl_of(C_GO | C_SINC, Z_W, Z_B));
    settle();
    chk("R4 lane-3 writes seen", 32'(exp_q.size()), 32'h0);

    // R11: misaligned source
    ws = writes_seen;
    setup(32'h61, 32'hD0, 4, ctl_of(C_GO | C_SINC | C_DINC, Z_H, Z_H));
    settle();
    rreg(2, r); chk("R11 misaligned flags error", r, (32'h1 << B_CFGE) | 32'h4);
    chk("R11 no write", 32'(writes_seen - ws), 32'h0);
    wreg(2, 32'h0100_0000);
    rreg(2, r); chk("R8 clears config error", r, 32'h0);

    // R11: count not a multiple of unit
    setup(32'h60, 32'hD0, 6, ctl_of(C_GO | C_SINC | C_DINC, Z_W, Z_W));
    settle();
    rreg(2, r); chk("R11 bad count flags error", r, (32'h1 << B_CFGE) | 32'h6);

    // R13: bus error on source read
    ws = writes_seen;
    setup(32'h200, 32'hD0, 4, ctl_of(C_GO | C_SINC | C_DINC, Z_W, Z_W));
    settle();
    rreg(2, r); chk("R13 bus error stops", r, (32'h1 << B_BUSE) | 32'h4);
    chk("R13 no write", 32'(writes_seen - ws), 32'h0);
    wreg(2, 32'h0100_0000);
    rreg(2, r); chk("R13 R8 error cleared", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule